// File: doc/BRIEF.md
# Cache Bandwidth Demand Predictor

This block turns first-level cache miss activity into a forecast of the bandwidth each running application will demand. It counts the miss pulses of every application over an evaluation interval. When the interval ends, each count is converted into a byte bandwidth by scaling it by the 32-byte line size. The result is pushed into a short per-application history window.

Once the window is full, a first-order least-squares line is fitted through the window, with the oldest sample at abscissa 0 and the newest at N-1. The line is evaluated a programmable number of intervals past the newest sample, and the result is clamped to a configured ceiling. The block also reports how far the previously published forecast was from the sample just measured. An interval ends either on a programmable cycle timer or on an external context-switch strobe.

After an interval end, one datapath updates the applications in turn. A single shared sequential divider supplies the one division each fit needs. The control is a state machine:

- IDLE: waiting. An accepted interval end moves it to SHIFT.
- SHIFT: pushes the snapshot into every history window, then moves to PREP.
- PREP: for the current application it either takes the fast path to STORE (window not full, or fitted value not positive) or starts the divider and moves to DIV.
- DIV: stays until the quotient is ready, then moves to STORE.
- STORE: records the application's forecast and error. It returns to PREP for the next application, or goes to PUBLISH after the last one.
- PUBLISH: copies all results to the outputs, raises `done_o` and returns to IDLE.

Top module: `bw_demand_predictor`

## Requirements
- R1: Each interval's sample for an application equals its miss count in that interval multiplied by 32, i.e. the count shifted left by 5 bits.
- R2: A miss counter saturates at 2^CNT_W-1 (1023 by default) and does not wrap.
- R3: With `cfg_ctx_mode_i`=1 an interval ends on each cycle `ctx_sw_i` is high and the timer never ends one. With `cfg_ctx_mode_i`=0 an interval ends every `cfg_len_i`+1 cycles, counted from the switch into timer mode, and `ctx_sw_i` is ignored. An interval end that arrives outside IDLE is dropped, and its misses carry over into the next accepted interval.
- R4: A miss pulse in the same cycle as an accepted interval end is counted in the following interval.
- R5: While fewer than N=HIST_N samples have been collected, the published forecast equals the newest sample and `valid_o` is 0. From the N-th sample on, `valid_o` is 1.
- R6: With a full window y0..y(N-1) (oldest first), the forecast is the least-squares line evaluated at abscissa N-1+H, truncated toward zero, where H is the effective horizon.
- R7: The effective horizon H is `cfg_horizon_i` limited to the range 1 to 10: a value of 0 acts as 1, and values above 10 act as 10.
- R8: A fitted forecast that is not positive is published as 0. A fitted forecast above `cfg_max_miss_i`*32 is published as `cfg_max_miss_i`*32.
- R9: The error output of an application is the absolute difference between its previously published forecast (0 after reset) and its newly measured sample.
- R10: `done_o` is a one-cycle pulse after each update. The forecast, error and `valid_o` outputs change only in the cycle `done_o` is high.
- R11: After reset all forecasts, errors, `valid_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | NAPP | One miss pulse bit per application |
| ctx_sw_i | input | 1 | Context-switch strobe that ends an interval in strobe mode |
| cfg_ctx_mode_i | input | 1 | 1: interval ends on the strobe; 0: interval ends on the timer |
| cfg_len_i | input | TMR_W | Timer interval length minus one, in cycles |
| cfg_horizon_i | input | 4 | Forecast horizon in intervals (effective 1..10) |
| cfg_max_miss_i | input | CNT_W | Maximum miss count per interval; ceiling is this value times 32 |
| pred_o | output | NAPP*BW_W | Published forecasts, application a at bits [a*BW_W +: BW_W] |
| err_o | output | NAPP*BW_W | Absolute error of the previous forecast, same packing |
| valid_o | output | 1 | History window full; forecasts come from the fit |
| done_o | output | 1 | One-cycle pulse when new outputs are published |

## Verification
A wrong history word, fill count or application index corrupts a forecast or error value. That corruption appears at the ports in the `done_o` cycle that closes the same interval, which is the only cycle in which the outputs may move. A reference model keeps its own sample windows and computes the least-squares forecast in a different algebraic form. It is compared with every output on every clock, so a stray output change between pulses is caught in the cycle it happens. A broken interval timer or strobe selection shows up as a shifted or missing `done_o` pulse, measured as the spacing between pulses.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_PREP,
        ST_DIV,
        ST_STORE,
        ST_PUBLISH
    } bwp_state_e;

    localparam int unsigned HORIZON_LIMIT = 10;

endpackage

// File: rtl/bwp_interval.sv
module bwp_interval #(
    parameter int unsigned NAPP  = 4,
    parameter int unsigned CNT_W = 10,
    parameter int unsigned TMR_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NAPP-1:0]         miss_i,
    input  logic                    ctx_sw_i,
    input  logic                    cfg_ctx_mode_i,
    input  logic [TMR_W-1:0]        cfg_len_i,
    input  logic                    accept_i,
    output logic                    take_o,
    output logic [NAPP*CNT_W-1:0]   snap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [TMR_W-1:0] tmr_q;
    logic             end_raw;

    // interval end source selected by mode
    assign end_raw = cfg_ctx_mode_i ? ctx_sw_i : (tmr_q == cfg_len_i);
    assign take_o  = end_raw & accept_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (cfg_ctx_mode_i) begin
            tmr_q <= '0;
        end else if (tmr_q == cfg_len_i) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NAPP; g++) begin : g_app
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] snap_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q  <= '0;
                snap_q <= '0;
            end else if (take_o) begin
                snap_q <= cnt_q;
                cnt_q  <= {{(CNT_W-1){1'b0}}, miss_i[g]};
            end else if (miss_i[g] && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end

        assign snap_o[g*CNT_W +: CNT_W] = snap_q;

        // R2: a full counter stays full under further misses
        a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (miss_i[g] && !take_o && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));

        // R4: a miss coincident with an accepted end starts the next count
        a_r4_carry_in: assert property (@(posedge clk) disable iff (!rst_n)
            take_o |=> (cnt_q == {{(CNT_W-1){1'b0}}, $past(miss_i[g])}));
    end

    // R3: in strobe mode nothing but the strobe closes an interval
    a_r3_strobe_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ctx_mode_i && !ctx_sw_i) |-> !take_o);

endmodule

// File: rtl/bwp_div.sv
module bwp_div #(
    parameter int unsigned     W       = 35,
    parameter longint unsigned DIVISOR = 160
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dvd_i,
    output logic         done_o,
    output logic [W-1:0] quot_o
);

    localparam int unsigned CW = $clog2(W + 1);
    localparam logic [W:0]  DV = (W+1)'(DIVISOR);
    localparam logic [CW-1:0] STEPS = CW'(W);

    logic [W:0]    rem_q;
    logic [W-1:0]  quot_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic          fits;

    assign shifted = {rem_q[W-1:0], quot_q[W-1]};
    assign fits    = (shifted >= DV);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quot_q <= '0;
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else if (start_i) begin
            rem_q  <= '0;
            quot_q <= dvd_i;
            cnt_q  <= STEPS;
            done_o <= 1'b0;
        end else if (cnt_q != '0) begin
            rem_q  <= fits ? (shifted - DV) : shifted;
            quot_q <= {quot_q[W-2:0], fits};
            cnt_q  <= cnt_q - 1'b1;
            done_o <= (cnt_q == CW'(1));
        end else begin
            done_o <= 1'b0;
        end
    end

    assign quot_o = quot_q;

    logic [2*W:0] prod_x;
    logic [2*W:0] dvd_x;
    assign prod_x = (2*W+1)'(quot_q) * (2*W+1)'(DV);
    assign dvd_x  = (2*W+1)'(dvd_i);

    // R6: the quotient handed to the fit is exact floor division
    a_r6_div_exact: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((prod_x <= dvd_x) && ((dvd_x - prod_x) < (2*W+1)'(DV))));

endmodule

// File: rtl/bwp_fit.sv
module bwp_fit #(
    parameter int unsigned N     = 4,
    parameter int unsigned BW_W  = 15,
    parameter int unsigned ACC_W = 35
) (
    input  logic [N*BW_W-1:0]        hist_i,
    input  logic [3:0]               horizon_i,
    output logic signed [ACC_W-1:0]  p2_o
);

    localparam int SX  = N * (N - 1) / 2;
    localparam int DEN = N * N * (N * N - 1) / 12;
    localparam logic signed [ACC_W-1:0] K_N   = ACC_W'(N);
    localparam logic signed [ACC_W-1:0] K_SX  = ACC_W'(SX);
    localparam logic signed [ACC_W-1:0] K_2D  = ACC_W'(2 * DEN);
    localparam logic signed [ACC_W-1:0] K_NM1 = ACC_W'(N - 1);

    logic signed [ACC_W-1:0] sum_y;
    logic signed [ACC_W-1:0] sum_xy;
    logic signed [ACC_W-1:0] slope_num;
    logic signed [ACC_W-1:0] t_twice;
    logic signed [ACC_W-1:0] yv;

    // doubled numerator of the line value at N-1+H over a fixed divisor 2*N*DEN
    always_comb begin
        sum_y  = '0;
        sum_xy = '0;
        yv     = '0;
        for (int i = 0; i < N; i++) begin
            yv     = $signed({{(ACC_W-BW_W){1'b0}}, hist_i[i*BW_W +: BW_W]});
            sum_y  = sum_y + yv;
            sum_xy = sum_xy + ACC_W'(i) * yv;
        end
        slope_num = K_N * sum_xy - K_SX * sum_y;
        t_twice   = K_NM1 + $signed({{(ACC_W-5){1'b0}}, horizon_i, 1'b0});
        p2_o      = K_2D * sum_y + K_N * slope_num * t_twice;
    end

endmodule

// File: rtl/bw_demand_predictor.sv
module bw_demand_predictor #(
    parameter int unsigned NAPP       = 4,
    parameter int unsigned CNT_W      = 10,
    parameter int unsigned HIST_N     = 4,
    parameter int unsigned TMR_W      = 16,
    parameter int unsigned LINE_SHIFT = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NAPP-1:0]                   miss_i,
    input  logic                              ctx_sw_i,
    input  logic                              cfg_ctx_mode_i,
    input  logic [TMR_W-1:0]                  cfg_len_i,
    input  logic [3:0]                        cfg_horizon_i,
    input  logic [CNT_W-1:0]                  cfg_max_miss_i,
    output logic [NAPP*(CNT_W+LINE_SHIFT)-1:0] pred_o,
    output logic [NAPP*(CNT_W+LINE_SHIFT)-1:0] err_o,
    output logic                              valid_o,
    output logic                              done_o
);

    import bwp_pkg::*;

    localparam int unsigned BW_W   = CNT_W + LINE_SHIFT;
    localparam int unsigned ACC_W  = BW_W + 6 * $clog2(HIST_N) + 8;
    localparam int unsigned IDX_W  = (NAPP > 1) ? $clog2(NAPP) : 1;
    localparam int unsigned FILL_W = $clog2(HIST_N + 1);
    localparam int unsigned LS_DEN = HIST_N * HIST_N * (HIST_N * HIST_N - 1) / 12;
    localparam longint unsigned DIV_Q = 2 * HIST_N * LS_DEN;
    localparam logic [IDX_W-1:0]  LAST_APP = IDX_W'(NAPP - 1);
    localparam logic [FILL_W-1:0] FULL     = FILL_W'(HIST_N);

    bwp_state_e state_q, state_d;

    logic [IDX_W-1:0]  app_q;
    logic [FILL_W-1:0] fill_q;
    logic [BW_W-1:0]   hist_q    [NAPP][HIST_N];
    logic [BW_W-1:0]   work_pred [NAPP];
    logic [BW_W-1:0]   work_err  [NAPP];
    logic [BW_W-1:0]   pub_pred  [NAPP];
    logic [BW_W-1:0]   pub_err   [NAPP];
    logic              valid_q;
    logic              done_q;

    // interval detection and per-application miss counting
    logic                    take;
    logic [NAPP*CNT_W-1:0]   snap;

    bwp_interval #(
        .NAPP  (NAPP),
        .CNT_W (CNT_W),
        .TMR_W (TMR_W)
    ) u_interval (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_i         (miss_i),
        .ctx_sw_i       (ctx_sw_i),
        .cfg_ctx_mode_i (cfg_ctx_mode_i),
        .cfg_len_i      (cfg_len_i),
        .accept_i       (state_q == ST_IDLE),
        .take_o         (take),
        .snap_o         (snap)
    );

    // window of the application under update
    logic [HIST_N*BW_W-1:0] sel_hist;
    logic [BW_W-1:0]        newest;
    logic [BW_W-1:0]        prev_pred;

    always_comb begin
        sel_hist = '0;
        for (int i = 0; i < HIST_N; i++) begin
            sel_hist[i*BW_W +: BW_W] = hist_q[app_q][i];
        end
    end

    assign newest    = hist_q[app_q][HIST_N-1];
    assign prev_pred = work_pred[app_q];

    // effective horizon
    logic [3:0] horizon;
    always_comb begin
        if (cfg_horizon_i == 4'd0) begin
            horizon = 4'd1;
        end else if (cfg_horizon_i > 4'(HORIZON_LIMIT)) begin
            horizon = 4'(HORIZON_LIMIT);
        end else begin
            horizon = cfg_horizon_i;
        end
    end

    logic signed [ACC_W-1:0] p2;

    bwp_fit #(
        .N     (HIST_N),
        .BW_W  (BW_W),
        .ACC_W (ACC_W)
    ) u_fit (
        .hist_i    (sel_hist),
        .horizon_i (horizon),
        .p2_o      (p2)
    );

    logic             warm;
    logic             p2_pos;
    logic             div_start;
    logic             div_done;
    logic [ACC_W-1:0] quot;

    assign warm      = (fill_q < FULL);
    assign p2_pos    = !p2[ACC_W-1] && (p2 != '0);
    assign div_start = (state_q == ST_PREP) && !warm && p2_pos;

    bwp_div #(
        .W       (ACC_W),
        .DIVISOR (DIV_Q)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .dvd_i   (unsigned'(p2)),
        .done_o  (div_done),
        .quot_o  (quot)
    );

    // result of the current application
    logic [BW_W-1:0] max_bw;
    logic [BW_W-1:0] clamped;
    logic [BW_W-1:0] result;
    logic [BW_W-1:0] err_new;

    assign max_bw  = {cfg_max_miss_i, {LINE_SHIFT{1'b0}}};
    assign clamped = (quot > ACC_W'(max_bw)) ? max_bw : quot[BW_W-1:0];

    always_comb begin
        if (warm) begin
            result = newest;
        end else if (!p2_pos) begin
            result = '0;
        end else begin
            result = clamped;
        end
        err_new = (prev_pred >= newest) ? (prev_pred - newest) : (newest - prev_pred);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (take) state_d = ST_SHIFT;
            ST_SHIFT:   state_d = ST_PREP;
            ST_PREP:    state_d = div_start ? ST_DIV : ST_STORE;
            ST_DIV:     if (div_done) state_d = ST_STORE;
            ST_STORE:   state_d = (app_q == LAST_APP) ? ST_PUBLISH : ST_PREP;
            ST_PUBLISH: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            app_q   <= '0;
            fill_q  <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            for (int a = 0; a < NAPP; a++) begin
                work_pred[a] <= '0;
                work_err[a]  <= '0;
                pub_pred[a]  <= '0;
                pub_err[a]   <= '0;
                for (int i = 0; i < HIST_N; i++) begin
                    hist_q[a][i] <= '0;
                end
            end
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_SHIFT: begin
                    for (int a = 0; a < NAPP; a++) begin
                        for (int i = 0; i < HIST_N - 1; i++) begin
                            hist_q[a][i] <= hist_q[a][i+1];
                        end
                        hist_q[a][HIST_N-1] <= {snap[a*CNT_W +: CNT_W], {LINE_SHIFT{1'b0}}};
                    end
                    if (fill_q != FULL) begin
                        fill_q <= fill_q + 1'b1;
                    end
                    app_q <= '0;
                end
                ST_STORE: begin
                    work_pred[app_q] <= result;
                    work_err[app_q]  <= err_new;
                    if (app_q != LAST_APP) begin
                        app_q <= app_q + 1'b1;
                    end
                end
                ST_PUBLISH: begin
                    for (int a = 0; a < NAPP; a++) begin
                        pub_pred[a] <= work_pred[a];
                        pub_err[a]  <= work_err[a];
                    end
                    valid_q <= (fill_q == FULL);
                    done_q  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < NAPP; g++) begin : g_out
        assign pred_o[g*BW_W +: BW_W] = pub_pred[g];
        assign err_o[g*BW_W +: BW_W]  = pub_err[g];

        // R8: a published fitted forecast never exceeds the ceiling
        a_r8_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && valid_o) |-> (pred_o[g*BW_W +: BW_W] <= max_bw));
    end

    assign valid_o = valid_q;
    assign done_o  = done_q;

    // R10: completion is a single-cycle pulse
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: outputs move only together with the completion pulse
    a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(pred_o) && $stable(err_o) && $stable(valid_o)));

    // R5: the window-full flag can only appear with a publication
    a_r5_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> done_o);

endmodule

// File: tb/bw_demand_predictor_test.sv
module bw_demand_predictor_test;

    localparam int NAPP  = 4;
    localparam int CNT_W = 10;
    localparam int HN    = 4;
    localparam int TMR_W = 16;
    localparam int BW_W  = 15;
    localparam int CMAX  = 1023;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                   rst_n;
    logic [NAPP-1:0]        miss_i;
    logic                   ctx_sw_i;
    logic                   cfg_ctx_mode_i;
    logic [TMR_W-1:0]       cfg_len_i;
    logic [3:0]             cfg_horizon_i;
    logic [CNT_W-1:0]       cfg_max_miss_i;
    logic [NAPP*BW_W-1:0]   pred_o;
    logic [NAPP*BW_W-1:0]   err_o;
    logic                   valid_o;
    logic                   done_o;

    bw_demand_predictor uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_i         (miss_i),
        .ctx_sw_i       (ctx_sw_i),
        .cfg_ctx_mode_i (cfg_ctx_mode_i),
        .cfg_len_i      (cfg_len_i),
        .cfg_horizon_i  (cfg_horizon_i),
        .cfg_max_miss_i (cfg_max_miss_i),
        .pred_o         (pred_o),
        .err_o          (err_o),
        .valid_o        (valid_o),
        .done_o         (done_o)
    );

    int     n_run  = 0;
    int     n_fail = 0;
    longint cyc    = 0;
    bit     finished = 1'b0;

    // reference model state
    longint mh [NAPP][HN];
    int     mfill = 0;
    longint mprev [NAPP];
    longint epred [NAPP];
    longint eerr  [NAPP];
    bit     evalid = 1'b0;
    int     sq [$];
    int     pend_carry = 0;
    longint last_done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff_hz();
        if (cfg_horizon_i == 0) return 1;
        if (cfg_horizon_i > 10) return 10;
        return int'(cfg_horizon_i);
    endfunction

    function automatic longint fit_model(input int a);
        longint sy = 0, sxy = 0, sx = 0, sxx = 0;
        longint den, nb, t, numer, v, ceil_v;
        for (int i = 0; i < HN; i++) begin
            sy  += mh[a][i];
            sxy += i * mh[a][i];
            sx  += i;
            sxx += i * i;
        end
        den    = HN * sxx - sx * sx;
        nb     = HN * sxy - sx * sy;
        t      = HN - 1 + eff_hz();
        numer  = sy * den + nb * (HN * t - sx);
        ceil_v = longint'(cfg_max_miss_i) * 32;
        if (numer <= 0) return 0;
        v = numer / (HN * den);
        if (v > ceil_v) v = ceil_v;
        return v;
    endfunction

    task automatic commit();
        longint s [NAPP];
        for (int a = 0; a < NAPP; a++) s[a] = 0;
        if (sq.size() >= NAPP) begin
            for (int a = 0; a < NAPP; a++) s[a] = longint'(sq.pop_front()) * 32;
        end
        for (int a = 0; a < NAPP; a++) begin
            for (int i = 0; i < HN - 1; i++) mh[a][i] = mh[a][i+1];
            mh[a][HN-1] = s[a];
        end
        if (mfill < HN) mfill++;
        for (int a = 0; a < NAPP; a++) begin
            longint np;
            np = (mfill < HN) ? s[a] : fit_model(a);
            eerr[a]  = (mprev[a] > s[a]) ? mprev[a] - s[a] : s[a] - mprev[a];
            mprev[a] = np;
            epred[a] = np;
        end
        evalid = (mfill >= HN);
    endtask

    // compare every clock
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (done_o) begin
                commit();
                last_done = cyc;
            end
            for (int a = 0; a < NAPP; a++) begin
                chk("R6", $sformatf("pred app%0d", a), longint'(pred_o[a*BW_W +: BW_W]), epred[a]);
                chk("R9", $sformatf("err app%0d", a), longint'(err_o[a*BW_W +: BW_W]), eerr[a]);
            end
            chk("R5", "valid", longint'(valid_o), longint'(evalid));
        end
    end

    task automatic wait_done(input int limit, input string req);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!done_o && k < limit);
        chk(req, "done pulse seen", longint'(done_o), 1);
        @(negedge clk);
    endtask

    task automatic run_iv(input int c0, input int c1, input int c2, input int c3, input bit carry);
        int c [NAPP];
        int mx = 0;
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
        for (int a = 0; a < NAPP; a++) if (c[a] > mx) mx = c[a];
        for (int i = 0; i < mx; i++) begin
            @(negedge clk);
            for (int a = 0; a < NAPP; a++) miss_i[a] = (i < c[a]);
        end
        @(negedge clk);
        ctx_sw_i = 1'b1;
        miss_i   = carry ? 4'b0001 : 4'b0000;
        for (int a = 0; a < NAPP; a++) begin
            int v;
            v = c[a] + ((a == 0) ? pend_carry : 0);
            if (v > CMAX) v = CMAX;
            sq.push_back(v);
        end
        pend_carry = carry ? 1 : 0;
        @(negedge clk);
        ctx_sw_i = 1'b0;
        miss_i   = '0;
        wait_done(500, "R10");
    endtask

    function automatic longint pslot(input logic [NAPP*BW_W-1:0] v, input int a);
        return longint'(v[a*BW_W +: BW_W]);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        n_fail++;
        n_run++;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        longint t5, t6;
        bit seen;
        for (int a = 0; a < NAPP; a++) begin
            mprev[a] = 0; epred[a] = 0; eerr[a] = 0;
            for (int i = 0; i < HN; i++) mh[a][i] = 0;
        end
        rst_n = 1'b0;
        miss_i = '0;
        ctx_sw_i = 1'b0;
        cfg_ctx_mode_i = 1'b1;
        cfg_len_i = 16'd299;
        cfg_horizon_i = 4'd1;
        cfg_max_miss_i = 10'd1023;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk("R11", "pred app0", pslot(pred_o, 0), 0);
        chk("R11", "err app3", pslot(err_o, 3), 0);
        chk("R11", "valid", longint'(valid_o), 0);
        chk("R11", "done", longint'(done_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // warm-up: newest sample is published
        run_iv(1, 40, 5, 0, 1'b0);
        @(negedge clk);
        chk("R1", "warm sample app0", pslot(pred_o, 0), 32);
        chk("R5", "warm valid", longint'(valid_o), 0);
        run_iv(2, 30, 5, 0, 1'b0);
        run_iv(3, 20, 5, 0, 1'b0);
        chk("R1", "warm sample app1", pslot(pred_o, 1), 640);
        run_iv(4, 10, 5, 0, 1'b0);
        @(negedge clk);
        chk("R5", "valid after full window", longint'(valid_o), 1);
        chk("R6", "ramp app0 H=1", pslot(pred_o, 0), 160);
        chk("R9", "err app0 vs warm forecast", pslot(err_o, 0), 32);
        chk("R6", "flat app2", pslot(pred_o, 2), 160);

        // falling trend goes negative
        run_iv(5, 0, 5, 0, 1'b0);
        @(negedge clk);
        chk("R8", "negative forecast floor app1", pslot(pred_o, 1), 0);

        // ceiling
        cfg_max_miss_i = 10'd50;
        run_iv(6, 0, 40, 0, 1'b0);
        run_iv(7, 0, 45, 0, 1'b0);
        run_iv(8, 0, 50, 0, 1'b0);
        run_iv(9, 0, 55, 0, 1'b0);
        @(negedge clk);
        chk("R8", "ceiling app2", pslot(pred_o, 2), 1600);
        chk("R6", "ramp app0 iv9", pslot(pred_o, 0), 320);

        // horizon limits
        cfg_horizon_i = 4'd0;
        run_iv(10, 0, 5, 0, 1'b0);
        @(negedge clk);
        chk("R7", "horizon 0 acts as 1", pslot(pred_o, 0), 352);
        cfg_horizon_i = 4'd15;
        run_iv(11, 0, 5, 0, 1'b0);
        @(negedge clk);
        chk("R7", "horizon 15 acts as 10", pslot(pred_o, 0), 672);
        cfg_horizon_i = 4'd3;
        run_iv(12, 0, 5, 0, 1'b0);
        @(negedge clk);
        chk("R6", "horizon 3", pslot(pred_o, 0), 480);

        // miss in the closing cycle belongs to the next interval
        run_iv(13, 0, 5, 0, 1'b1);
        run_iv(0, 0, 5, 0, 1'b0);
        @(negedge clk);
        chk("R4", "carried miss err app0", pslot(err_o, 0), 480);

        // counter saturation
        run_iv(15, 0, 5, 1100, 1'b0);
        @(negedge clk);
        chk("R2", "saturated sample err app3", pslot(err_o, 3), 32736);

        // timer mode
        cfg_ctx_mode_i = 1'b0;
        t5 = 0;
        t6 = 0;
        for (int n = 1; n <= 6; n++) begin
            if (n == 6) begin
                repeat (50) @(negedge clk);
                ctx_sw_i = 1'b1;
                @(negedge clk);
                ctx_sw_i = 1'b0;
            end
            wait_done(1000, "R3");
            if (n == 5) t5 = last_done;
            if (n == 6) t6 = last_done;
        end
        chk("R3", "timer period with strobe ignored", t6 - t5, 300);
        cfg_ctx_mode_i = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            if (done_o) seen = 1'b1;
        end
        chk("R3", "no timer end in strobe mode", longint'(seen), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule